// File: doc/BRIEF.md
# Single-Cycle 32-Bit Load/Store Processor Core

This block is a small processor that completes one instruction in each clock cycle. It runs a subset of a classic 32-bit instruction set with three instruction formats. Register-register arithmetic and set-less-than use the R format. Immediate arithmetic, logic, upper-constant load, word load/store and the two compare-and-branch instructions use the I format. The one jump uses the J format. Every instruction is one 32-bit word. The register file has 32 entries of 32 bits, and entry 0 is fixed at zero.

The instruction store and the data store are word arrays inside the core. The surrounding logic holds the core in reset and fills both arrays through a preload port. It then releases reset and lets the program run. Results are read back through a combinational register-inspection port. An unsupported encoding or a misaligned word access stops the core. A sticky halt output then goes high and the architectural state stays frozen until the next reset.

Top module: `sc_risc_core`

## Requirements
- R1: While `rst` is high at a clock edge, the PC becomes 0, `halted` becomes 0 and every register reads 0. After `rst` falls, execution starts at byte address 0.
- R2: Register 0 always reads 0, and any instruction that targets it leaves it at 0.
- R3: The R format (op 0) takes rs from bits 25:21, rt from 20:16 and rd from 15:11, with the destination in rd. funct 100000 adds, 100010 subtracts (rs minus rt) and 101010 writes 1 when rs < rt as signed values, else 0. Results wrap modulo 2^32. A nonzero shamt field (bits 10:6) makes the instruction unsupported.
- R4: In the I format (imm in bits 15:0, destination rt), addi (op 8) and slti (op 10) sign-extend the immediate. andi (op 12) and ori (op 13) zero-extend it.
- R5: lui (op 15) writes the immediate to bits 31:16 with bits 15:0 cleared. A following ori completes any 32-bit constant.
- R6: lw (op 35) loads rt from byte address rs + sign-extended imm. sw (op 43) stores rt to that address. The word index is address bits above bit 1.
- R7: beq (op 4) and bne (op 5) compare rs with rt. When taken, the next PC is PC+4 + (sign-extended imm << 2); otherwise it is PC+4. This holds for forward and backward offsets.
- R8: j (op 2) jumps to {bits 31:28 of PC+4, 26-bit index, 2'b00}.
- R9: An unsupported opcode or funct sets `halted`. `halted` stays set until reset. That instruction and all later ones write neither registers nor memory, and the PC stays frozen.
- R10: lw or sw with a nonzero low two address bits sets `halted` and writes neither memory nor registers.
- R11: A preload writes `ld_data` to word `ld_addr` of the instruction store when `ld_sel` is 0, or of the data store when it is 1. Store contents survive reset.
- R12: `dbg_val` shows register `dbg_idx` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ld_en | input | 1 | Preload write strobe |
| ld_sel | input | 1 | Preload target: 0 instruction store, 1 data store |
| ld_addr | input | LAW (6) | Preload word index |
| ld_data | input | 32 | Preload word |
| dbg_idx | input | 5 | Register to inspect |
| dbg_val | output | 32 | Value of the inspected register |
| halted | output | 1 | Sticky stop flag |

## Verification
A fault in the decoder or ALU corrupts a register on the same edge. That register shows the error on the inspection port at once, and the error spreads through any later instruction that reads it. A wrong next-PC computation shows up as a skipped or extra instruction, so a marker register that should stay untouched changes, or a loop counter ends at the wrong count. A halt that fails to latch, or fails to freeze the core, lets the instruction after a bad encoding write its marker. A store that escapes on a misaligned address is exposed by reloading that word after a reset.

// File: rtl/sc_risc_pkg.sv
`timescale 1ns/1ps
package sc_risc_pkg;
   localparam int XLEN = 32;
   localparam int NREG = 32;
   localparam int RIDX = 5;

   localparam logic [5:0] OP_RTYPE = 6'd0;
   localparam logic [5:0] OP_J     = 6'd2;
   localparam logic [5:0] OP_BEQ   = 6'd4;
   localparam logic [5:0] OP_BNE   = 6'd5;
   localparam logic [5:0] OP_ADDI  = 6'd8;
   localparam logic [5:0] OP_SLTI  = 6'd10;
   localparam logic [5:0] OP_ANDI  = 6'd12;
   localparam logic [5:0] OP_ORI   = 6'd13;
   localparam logic [5:0] OP_LUI   = 6'd15;
   localparam logic [5:0] OP_LW    = 6'd35;
   localparam logic [5:0] OP_SW    = 6'd43;

   localparam logic [5:0] FN_ADD = 6'b100000;
   localparam logic [5:0] FN_SUB = 6'b100010;
   localparam logic [5:0] FN_SLT = 6'b101010;

   typedef enum logic [2:0] {
      ALU_ADD, ALU_SUB, ALU_SLT, ALU_AND, ALU_OR, ALU_PASSB
   } alu_op_e;

   typedef enum logic [1:0] {
      IMM_SEXT, IMM_ZEXT, IMM_UPPER
   } imm_kind_e;

   typedef struct packed {
      logic      reg_we;
      logic      dst_is_rd;
      logic      use_imm;
      imm_kind_e imm_kind;
      alu_op_e   alu_op;
      logic      mem_rd;
      logic      mem_wr;
      logic      branch;
      logic      branch_ne;
      logic      jump;
      logic      illegal;
   } ctrl_t;
endpackage

// File: rtl/sc_decoder.sv
`timescale 1ns/1ps
module sc_decoder
   import sc_risc_pkg::*;
(
   input  logic [5:0] op,
   input  logic [4:0] shamt,
   input  logic [5:0] funct,
   input  logic       clk,
   input  logic       rst,
   output ctrl_t      ctl
);
   always_comb begin
      ctl = '0;
      unique case (op)
         OP_RTYPE: begin
            ctl.reg_we    = 1'b1;
            ctl.dst_is_rd = 1'b1;
            if (shamt != 5'd0) begin
               ctl.illegal = 1'b1;
            end else begin
               case (funct)
                  FN_ADD:  ctl.alu_op = ALU_ADD;
                  FN_SUB:  ctl.alu_op = ALU_SUB;
                  FN_SLT:  ctl.alu_op = ALU_SLT;
                  default: ctl.illegal = 1'b1;
               endcase
            end
            if (ctl.illegal) ctl.reg_we = 1'b0;
         end
         OP_ADDI: begin
            ctl.reg_we = 1'b1; ctl.use_imm = 1'b1;
            ctl.imm_kind = IMM_SEXT; ctl.alu_op = ALU_ADD;
         end
         OP_SLTI: begin
            ctl.reg_we = 1'b1; ctl.use_imm = 1'b1;
            ctl.imm_kind = IMM_SEXT; ctl.alu_op = ALU_SLT;
         end
         OP_ANDI: begin
            ctl.reg_we = 1'b1; ctl.use_imm = 1'b1;
            ctl.imm_kind = IMM_ZEXT; ctl.alu_op = ALU_AND;
         end
         OP_ORI: begin
            ctl.reg_we = 1'b1; ctl.use_imm = 1'b1;
            ctl.imm_kind = IMM_ZEXT; ctl.alu_op = ALU_OR;
         end
         OP_LUI: begin
            ctl.reg_we = 1'b1; ctl.use_imm = 1'b1;
            ctl.imm_kind = IMM_UPPER; ctl.alu_op = ALU_PASSB;
         end
         OP_LW: begin
            ctl.reg_we = 1'b1; ctl.use_imm = 1'b1; ctl.mem_rd = 1'b1;
            ctl.imm_kind = IMM_SEXT; ctl.alu_op = ALU_ADD;
         end
         OP_SW: begin
            ctl.use_imm = 1'b1; ctl.mem_wr = 1'b1;
            ctl.imm_kind = IMM_SEXT; ctl.alu_op = ALU_ADD;
         end
         OP_BEQ: ctl.branch = 1'b1;
         OP_BNE: begin
            ctl.branch = 1'b1; ctl.branch_ne = 1'b1;
         end
         OP_J:    ctl.jump = 1'b1;
         default: ctl.illegal = 1'b1;
      endcase
   end

   // R6/R7/R8: at most one kind of memory or flow-control action per instruction
   assert_one_action_R6: assert property (@(posedge clk) disable iff (rst)
      $onehot0({ctl.mem_rd, ctl.mem_wr, ctl.branch, ctl.jump}));
endmodule

// File: rtl/sc_alu.sv
`timescale 1ns/1ps
module sc_alu
   import sc_risc_pkg::*;
#(
   parameter int W = XLEN
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  alu_op_e      op,
   output logic [W-1:0] y
);
   always_comb begin
      case (op)
         ALU_ADD:   y = a + b;
         ALU_SUB:   y = a - b;
         ALU_SLT:   y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
         ALU_AND:   y = a & b;
         ALU_OR:    y = a | b;
         ALU_PASSB: y = b;
         default:   y = '0;
      endcase
   end
endmodule

// File: rtl/sc_regfile.sv
`timescale 1ns/1ps
module sc_regfile
   import sc_risc_pkg::*;
#(
   parameter int W = XLEN,
   parameter int N = NREG,
   localparam int AW = $clog2(N)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [W-1:0]  wdata,
   input  logic [AW-1:0] ra1,
   input  logic [AW-1:0] ra2,
   input  logic [AW-1:0] ra3,
   output logic [W-1:0]  rd1,
   output logic [W-1:0]  rd2,
   output logic [W-1:0]  rd3
);
   logic [W-1:0] view [N];

   // entry 0 has no storage: it is a constant zero
   assign view[0] = '0;

   for (genvar g = 1; g < N; g++) begin : g_reg
      logic [W-1:0] q;
      always_ff @(posedge clk) begin
         if (rst)                         q <= '0;
         else if (we && waddr == AW'(g))  q <= wdata;
      end
      assign view[g] = q;
   end

   assign rd1 = view[ra1];
   assign rd2 = view[ra2];
   assign rd3 = view[ra3];
endmodule

// File: rtl/sc_wordram.sv
`timescale 1ns/1ps
module sc_wordram #(
   parameter int W     = 32,
   parameter int WORDS = 64,
   localparam int AW   = $clog2(WORDS)
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [W-1:0]  wdata,
   input  logic [AW-1:0] raddr,
   output logic [W-1:0]  rdata
);
   logic [W-1:0] mem [WORDS];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/sc_risc_core.sv
`timescale 1ns/1ps
module sc_risc_core
   import sc_risc_pkg::*;
#(
   parameter int  IMEM_WORDS = 64,
   parameter int  DMEM_WORDS = 64,
   localparam int IAW = $clog2(IMEM_WORDS),
   localparam int DAW = $clog2(DMEM_WORDS),
   localparam int LAW = (IAW > DAW) ? IAW : DAW
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            ld_en,
   input  logic            ld_sel,
   input  logic [LAW-1:0]  ld_addr,
   input  logic [XLEN-1:0] ld_data,
   input  logic [RIDX-1:0] dbg_idx,
   output logic [XLEN-1:0] dbg_val,
   output logic            halted
);
   if (IMEM_WORDS < 2 || (IMEM_WORDS & (IMEM_WORDS - 1)) != 0) begin : g_bad_imem
      $error("IMEM_WORDS must be a power of two of at least 2");
   end
   if (DMEM_WORDS < 2 || (DMEM_WORDS & (DMEM_WORDS - 1)) != 0) begin : g_bad_dmem
      $error("DMEM_WORDS must be a power of two of at least 2");
   end

   logic [XLEN-1:0] pc, pc_plus4, pc_next, br_target, j_target;
   logic [XLEN-1:0] instr, rs_val, rt_val, imm_ext, alu_b, alu_y, wb_data, dm_rdata;
   logic [RIDX-1:0] f_rs, f_rt, f_rd, dst;
   logic [15:0]     f_imm;
   ctrl_t           ctl;
   logic            misalign, trap, run, rf_we, dm_core_we, taken;

   // ---------------- instruction store ----------------
   sc_wordram #(.W(XLEN), .WORDS(IMEM_WORDS)) u_imem (
      .clk   (clk),
      .we    (ld_en && !ld_sel),
      .waddr (ld_addr[IAW-1:0]),
      .wdata (ld_data),
      .raddr (pc[IAW+1:2]),
      .rdata (instr)
   );

   assign f_rs  = instr[25:21];
   assign f_rt  = instr[20:16];
   assign f_rd  = instr[15:11];
   assign f_imm = instr[15:0];

   sc_decoder u_dec (
      .op    (instr[31:26]),
      .shamt (instr[10:6]),
      .funct (instr[5:0]),
      .clk   (clk),
      .rst   (rst),
      .ctl   (ctl)
   );

   // ---------------- operands ----------------
   always_comb begin
      case (ctl.imm_kind)
         IMM_ZEXT:  imm_ext = {16'h0000, f_imm};
         IMM_UPPER: imm_ext = {f_imm, 16'h0000};
         default:   imm_ext = {{16{f_imm[15]}}, f_imm};
      endcase
   end

   assign alu_b = ctl.use_imm ? imm_ext : rt_val;
   assign dst   = ctl.dst_is_rd ? f_rd : f_rt;

   sc_alu #(.W(XLEN)) u_alu (
      .a  (rs_val),
      .b  (alu_b),
      .op (ctl.alu_op),
      .y  (alu_y)
   );

   // ---------------- data store ----------------
   assign misalign   = (ctl.mem_rd || ctl.mem_wr) && (alu_y[1:0] != 2'b00);
   assign trap       = ctl.illegal || misalign;
   assign run        = !rst && !halted && !trap;
   assign dm_core_we = run && ctl.mem_wr;

   logic            dm_we;
   logic [DAW-1:0]  dm_waddr;
   logic [XLEN-1:0] dm_wdata;

   always_comb begin
      if (ld_en && ld_sel) begin
         dm_we = 1'b1; dm_waddr = ld_addr[DAW-1:0]; dm_wdata = ld_data;
      end else begin
         dm_we = dm_core_we; dm_waddr = alu_y[DAW+1:2]; dm_wdata = rt_val;
      end
   end

   sc_wordram #(.W(XLEN), .WORDS(DMEM_WORDS)) u_dmem (
      .clk   (clk),
      .we    (dm_we),
      .waddr (dm_waddr),
      .wdata (dm_wdata),
      .raddr (alu_y[DAW+1:2]),
      .rdata (dm_rdata)
   );

   // ---------------- register file ----------------
   assign rf_we   = run && ctl.reg_we;
   assign wb_data = ctl.mem_rd ? dm_rdata : alu_y;

   sc_regfile #(.W(XLEN), .N(NREG)) u_rf (
      .clk   (clk),
      .rst   (rst),
      .we    (rf_we),
      .waddr (dst),
      .wdata (wb_data),
      .ra1   (f_rs),
      .ra2   (f_rt),
      .ra3   (dbg_idx),
      .rd1   (rs_val),
      .rd2   (rt_val),
      .rd3   (dbg_val)
   );

   // ---------------- next PC ----------------
   assign pc_plus4  = pc + 32'd4;
   assign br_target = pc_plus4 + {{14{f_imm[15]}}, f_imm, 2'b00};
   assign j_target  = {pc_plus4[31:28], instr[25:0], 2'b00};
   assign taken     = ctl.branch && ((rs_val == rt_val) != ctl.branch_ne);

   always_comb begin
      if (ctl.jump)  pc_next = j_target;
      else if (taken) pc_next = br_target;
      else            pc_next = pc_plus4;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         pc     <= '0;
         halted <= 1'b0;
      end else if (!halted) begin
         if (trap) halted <= 1'b1;
         else      pc     <= pc_next;
      end
   end

   // ---------------- assertions ----------------
   assert_halt_sticky_R9: assert property (@(posedge clk) disable iff (rst)
      halted |=> halted);
   assert_pc_frozen_R9: assert property (@(posedge clk) disable iff (rst)
      halted |=> $stable(pc));
   assert_no_store_halted_R9: assert property (@(posedge clk) disable iff (rst)
      halted |-> !dm_core_we && !rf_we);
   assert_store_aligned_R10: assert property (@(posedge clk) disable iff (rst)
      dm_core_we |-> (alu_y[1:0] == 2'b00));
   assert_pc_word_aligned_R7: assert property (@(posedge clk) disable iff (rst)
      pc[1:0] == 2'b00);
endmodule

// File: tb/sc_risc_core_test.sv
`timescale 1ns/1ps
module sc_risc_core_test;
   logic        clk = 1'b0;
   logic        rst;
   logic        ld_en, ld_sel;
   logic [5:0]  ld_addr;
   logic [31:0] ld_data;
   logic [4:0]  dbg_idx;
   logic [31:0] dbg_val;
   logic        halted;
   int          n_checks = 0;
   int          n_errors = 0;

   always #5 clk = ~clk;

   sc_risc_core uut (
      .clk(clk), .rst(rst), .ld_en(ld_en), .ld_sel(ld_sel), .ld_addr(ld_addr),
      .ld_data(ld_data), .dbg_idx(dbg_idx), .dbg_val(dbg_val), .halted(halted)
   );

   // expected register contents after program 1: {index, value}
   localparam logic [36:0] EXPECT [18] = '{
      {5'd0,  32'h0000_0000},  // R2 write to r0 discarded
      {5'd1,  32'h0000_0005},  // R4 addi
      {5'd2,  32'hFFFF_FFFD},  // R4 addi negative, sign-extended
      {5'd3,  32'h0000_0002},  // R3 add
      {5'd4,  32'hFFFF_FFF8},  // R3 sub
      {5'd5,  32'h0000_0001},  // R3 slt signed true
      {5'd6,  32'h0000_0000},  // R3 slt signed false
      {5'd7,  32'h0000_0001},  // R4 slti sign-extended
      {5'd8,  32'h1234_ABCD},  // R5 lui + ori
      {5'd9,  32'h0000_F0F0},  // R4 andi zero-extended
      {5'd10, 32'h1234_ABCD},  // R6 sw then lw
      {5'd11, 32'hCAFE_F00D},  // R6 lw of preloaded word
      {5'd12, 32'h0000_0001},  // R7 beq not taken falls through
      {5'd13, 32'h0000_0000},  // R7 taken branches skip
      {5'd14, 32'h0000_0000},  // R8 jump skips
      {5'd15, 32'h0000_7FFF},  // R8 jump target reached
      {5'd16, 32'h0000_0003},  // R7 backward branch loop count
      {5'd17, 32'h0000_0000}   // R7 loop exit condition
   };

   function automatic logic [31:0] enc_i(input int op, input int rs, input int rt, input int imm);
      return {op[5:0], rs[4:0], rt[4:0], imm[15:0]};
   endfunction
   function automatic logic [31:0] enc_r(input int fn, input int rs, input int rt, input int rd);
      return {6'd0, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn[5:0]};
   endfunction
   function automatic logic [31:0] enc_j(input int idx);
      return {6'd2, idx[25:0]};
   endfunction

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_errors++;
         $display("FAIL %s: got %08h expected %08h", req, got, exp);
      end
   endtask

   task automatic read_reg(input int idx, output logic [31:0] v);
      dbg_idx = idx[4:0];
      #1;
      v = dbg_val;
   endtask

   task automatic preload(input logic sel, input int addr, input logic [31:0] data);
      @(negedge clk);
      ld_en = 1'b1; ld_sel = sel; ld_addr = addr[5:0]; ld_data = data;
      @(negedge clk);
      ld_en = 1'b0;
   endtask

   task automatic reset_cycles(input int n);
      @(negedge clk);
      rst = 1'b1;
      repeat (n) @(negedge clk);
   endtask

   task automatic run_cycles(input int n);
      @(negedge clk);
      rst = 1'b0;
      repeat (n) @(negedge clk);
   endtask

   initial begin
      #1_000_000;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      logic [31:0] v;
      rst = 1'b1; ld_en = 1'b0; ld_sel = 1'b0; ld_addr = '0; ld_data = '0; dbg_idx = '0;
      repeat (2) @(negedge clk);

      // R1: reset state
      check("R1 halted low in reset", {31'd0, halted}, 32'd0);
      read_reg(5, v);
      check("R1 register cleared in reset", v, 32'd0);
      read_reg(0, v);
      check("R12 r0 read", v, 32'd0);

      // data store preload (R11)
      preload(1'b1, 0, 32'hCAFE_F00D);
      preload(1'b1, 1, 32'h0BAD_BEEF);

      // program 1
      preload(1'b0, 0,  enc_i(8, 0, 1, 5));
      preload(1'b0, 1,  enc_i(8, 0, 2, -3));
      preload(1'b0, 2,  enc_r(32, 1, 2, 3));
      preload(1'b0, 3,  enc_r(34, 2, 1, 4));
      preload(1'b0, 4,  enc_r(42, 2, 1, 5));
      preload(1'b0, 5,  enc_r(42, 1, 2, 6));
      preload(1'b0, 6,  enc_i(10, 2, 7, -2));
      preload(1'b0, 7,  enc_i(15, 0, 8, 'h1234));
      preload(1'b0, 8,  enc_i(13, 8, 8, 'hABCD));
      preload(1'b0, 9,  enc_i(12, 2, 9, 'hF0F0));
      preload(1'b0, 10, enc_i(8, 0, 0, 7));
      preload(1'b0, 11, enc_i(43, 0, 8, 8));
      preload(1'b0, 12, enc_i(35, 0, 10, 8));
      preload(1'b0, 13, enc_i(35, 0, 11, 0));
      preload(1'b0, 14, enc_i(4, 1, 2, 1));
      preload(1'b0, 15, enc_i(8, 0, 12, 1));
      preload(1'b0, 16, enc_i(5, 1, 2, 1));
      preload(1'b0, 17, enc_i(8, 0, 13, 99));
      preload(1'b0, 18, enc_i(4, 3, 3, 1));
      preload(1'b0, 19, enc_i(8, 0, 13, 55));
      preload(1'b0, 20, enc_j(23));
      preload(1'b0, 21, enc_i(8, 0, 14, 1));
      preload(1'b0, 22, enc_i(8, 0, 14, 2));
      preload(1'b0, 23, enc_i(8, 0, 15, 'h7FFF));
      preload(1'b0, 24, enc_i(8, 16, 16, 1));
      preload(1'b0, 25, enc_i(10, 16, 17, 3));
      preload(1'b0, 26, enc_i(5, 17, 0, -3));
      preload(1'b0, 27, 32'hFC00_0000);
      preload(1'b0, 28, enc_i(8, 0, 18, 1));

      run_cycles(60);
      for (int i = 0; i < 18; i++) begin
         read_reg(int'(EXPECT[i][36:32]), v);
         check($sformatf("R3-table r%0d", EXPECT[i][36:32]), v, EXPECT[i][31:0]);
      end
      check("R9 halt on unsupported opcode", {31'd0, halted}, 32'd1);
      read_reg(18, v);
      check("R9 no execution after halt", v, 32'd0);
      repeat (5) @(negedge clk);
      check("R9 halt sticky", {31'd0, halted}, 32'd1);

      // program 2: misaligned store
      reset_cycles(2);
      check("R1 halt cleared by reset", {31'd0, halted}, 32'd0);
      read_reg(8, v);
      check("R1 registers cleared by reset", v, 32'd0);
      preload(1'b0, 0, enc_i(8, 0, 1, 'h55));
      preload(1'b0, 1, enc_i(43, 0, 1, 5));
      preload(1'b0, 2, enc_i(8, 0, 2, 9));
      run_cycles(10);
      check("R10 halt on misaligned sw", {31'd0, halted}, 32'd1);
      read_reg(1, v);
      check("R10 earlier instruction kept", v, 32'h55);
      read_reg(2, v);
      check("R10 later instruction suppressed", v, 32'd0);

      // program 3: check store untouched, illegal funct
      reset_cycles(2);
      preload(1'b0, 0, enc_i(35, 0, 3, 4));
      preload(1'b0, 1, enc_r(63, 0, 0, 4));
      preload(1'b0, 2, enc_i(8, 0, 5, 1));
      run_cycles(10);
      read_reg(3, v);
      check("R10 R11 data word unchanged across misaligned sw and reset", v, 32'h0BAD_BEEF);
      check("R9 halt on unsupported funct", {31'd0, halted}, 32'd1);
      read_reg(4, v);
      check("R9 unsupported funct writes nothing", v, 32'd0);
      read_reg(5, v);
      check("R9 frozen after funct halt", v, 32'd0);

      // program 4: misaligned load
      reset_cycles(2);
      preload(1'b0, 0, enc_i(8, 0, 6, 1));
      preload(1'b0, 1, enc_i(35, 6, 7, 0));
      run_cycles(10);
      check("R10 halt on misaligned lw", {31'd0, halted}, 32'd1);
      read_reg(7, v);
      check("R10 misaligned lw writes nothing", v, 32'd0);

      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end
endmodule